// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates two independent pulse-width modulated outputs from one input clock. Both channels share a single 32-bit control word. Each channel also has its own word that holds the period and the duty count. Every channel takes its counting tick from a divider, which is either one of a fixed set of decimal ratios or a straight pass-through of the clock. It then steps a 16-bit counter through one period. The output sits at the active level while the count is below the duty value, and the polarity of that level is selectable.

Software changes a running waveform by writing the channel's period/duty word. The value is parked in a shadow copy, and a busy flag in the control word stays up until the current period ends and the new value takes effect. The running waveform therefore never shows a torn period. A write to a stopped channel takes effect at once. The register bus is a plain word-addressed write/read port. Address bits [1:0] are ignored, and read data is a combinational function of the address.

Top module: `pwm2_ctl`

## Requirements
- R1: Word index 0 (byte offset 0x0) is the control word. Channel n's period/duty word sits at byte offset 0x4 + 4*n for n = 0, 1. A read of a period/duty word returns the value last written to it.
- R2: Channel n's control field is 10 bits wide and starts at bit 15*n. Field bits [3:0] are the divider code, bit 4 is enable, bit 5 is active-high select and bit 6 is clock gate. Bits 7, 8 and 9 are stored and read back but have no effect. All other control bits, apart from the busy flags, read as 0.
- R3: A channel counts only while both its enable bit and its gate bit are 1. Otherwise its counter is cleared and its output holds the inactive level.
- R4: In a period/duty word, bits [31:16] hold the period length minus one (P) and bits [15:0] hold the duty count (D). The counter runs 0..P, one step per divided tick, and the output is active while the count is below D. D = 0 gives a constant inactive level, and D > P gives a constant active level.
- R5: With the active-high bit at 1 the active level is 1. With it at 0 the output is inverted.
- R6: Divider codes 0..4 give one tick every 120, 180, 240, 360 or 480 clocks. Codes 8..12 give one tick every 12000, 24000, 36000, 48000 or 72000 clocks. Code 15 gives a tick on every clock.
- R7: Codes 5, 6, 7, 13 and 14 produce no ticks, so a running channel's counter holds its value.
- R8: Writing a running channel's period/duty word sets control bit 28+n (busy). The old value keeps driving the output until the count wraps from P to 0. At that wrap the new value takes over and busy clears.
- R9: A write to a stopped channel's period/duty word takes effect at once and leaves busy at 0. A pending value is also applied as soon as its channel stops.
- R10: Busy bits cannot be set by writing the control word.
- R11: After reset all control fields, counters and period/duty words are 0, and both outputs sit at the inactive level for active-high = 0, which is 1.
- R12: The two channels run independently. Traffic to one channel's word leaves the other channel's output and stored word untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the divider and all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Byte address; bits [3:2] select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| pwm_out | output | 2 | PWM outputs, bit n for channel n |

## Verification
The waveform is checked cycle by cycle with the pass-through divider, using a mid-range duty and a five-tick period. It is run under both polarities, so an inverted or off-by-one compare shows up at once. Duty values of zero and above the period test the two saturating ends of the compare. Two real divider codes are sampled at the exact tick where the first count change must land, and two unused codes must hold the count. These runs separate a wrong table entry from an off-by-one divider. A mid-period rewrite checks that busy holds until the wrap and that the new pattern starts on the following cycle. A stopped-channel write, a gate-only setting and a second-channel run separate immediate loading, the run condition and channel isolation.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int CNT_W      = 16;
  localparam int DIV_W      = 17;
  localparam int FLD_W      = 10;
  localparam int FLD_STRIDE = 15;
  localparam int RDY_BASE   = 28;

  typedef struct packed {
    logic       bypass;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act_hi;
    logic       en;
    logic [3:0] code;
  } ch_ctrl_t;

  function automatic logic [DIV_W-1:0] ratio_of(input logic [3:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      4'd0:    r = DIV_W'(120);
      4'd1:    r = DIV_W'(180);
      4'd2:    r = DIV_W'(240);
      4'd3:    r = DIV_W'(360);
      4'd4:    r = DIV_W'(480);
      4'd8:    r = DIV_W'(12000);
      4'd9:    r = DIV_W'(24000);
      4'd10:   r = DIV_W'(36000);
      4'd11:   r = DIV_W'(48000);
      4'd12:   r = DIV_W'(72000);
      4'd15:   r = DIV_W'(1);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm2_presc.sv
module pwm2_presc
  import pwm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);

  logic [DIV_W-1:0] ratio;
  logic [DIV_W-1:0] pcnt_q;
  logic             valid;

  assign ratio = ratio_of(code);
  assign valid = (ratio != '0);
  assign tick  = run && valid && (pcnt_q >= ratio - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!run || !valid || tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
  import pwm2_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               act_hi,
  input  logic               wr,
  input  logic [2*CNT_W-1:0] wdata,
  output logic [2*CNT_W-1:0] shadow_o,
  output logic               busy_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   duty_o,
  output logic               pwm_o
);

  logic [2*CNT_W-1:0] live_q;
  logic [2*CNT_W-1:0] shadow_q;
  logic               pend_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   prd;
  logic               wrap;

  assign prd    = live_q[2*CNT_W-1:CNT_W];
  assign duty_o = live_q[CNT_W-1:0];
  assign wrap   = tick && (cnt_q >= prd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (wr) begin
      shadow_q <= wdata;
      if (run) begin
        pend_q <= 1'b1;
      end else begin
        live_q <= wdata;
        pend_q <= 1'b0;
      end
    end else if (pend_q && (!run || wrap)) begin
      live_q <= shadow_q;
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign shadow_o = shadow_q;
  assign busy_o   = pend_q;
  assign cnt_o    = cnt_q;
  assign pwm_o    = (run && (cnt_q < duty_o)) ? act_hi : ~act_hi;

endmodule

// File: rtl/pwm2_ctl.sv
module pwm2_ctl
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]                     widx;
  ch_ctrl_t [NUM_CH-1:0]                 ctrl_q;
  logic [NUM_CH-1:0]                     run_w;
  logic [NUM_CH-1:0]                     tick_w;
  logic [NUM_CH-1:0]                     busy_w;
  logic [NUM_CH-1:0]                     act_w;
  logic [NUM_CH-1:0]                     chwr_w;
  logic [NUM_CH-1:0][3:0]                code_w;
  logic [NUM_CH-1:0][CNT_W-1:0]          cnt_w;
  logic [NUM_CH-1:0][CNT_W-1:0]          duty_w;
  logic [NUM_CH-1:0][2*CNT_W-1:0]        shadow_w;
  logic                                  unused_bits;

  assign widx        = reg_addr[ADDR_W-1:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_wr && (widx == '0)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctrl_q[c] <= reg_wdata[c*FLD_STRIDE +: FLD_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign run_w[c]  = ctrl_q[c].en && ctrl_q[c].gate;
    assign act_w[c]  = ctrl_q[c].act_hi;
    assign code_w[c] = ctrl_q[c].code;
    assign chwr_w[c] = reg_wr && (widx == WIDX_W'(c + 1));

    pwm2_presc u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_w[c]),
      .code  (ctrl_q[c].code),
      .tick  (tick_w[c])
    );

    pwm2_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w[c]),
      .tick     (tick_w[c]),
      .act_hi   (act_w[c]),
      .wr       (chwr_w[c]),
      .wdata    (reg_wdata),
      .shadow_o (shadow_w[c]),
      .busy_o   (busy_w[c]),
      .cnt_o    (cnt_w[c]),
      .duty_o   (duty_w[c]),
      .pwm_o    (pwm_out[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (widx == '0) begin
      for (int c = 0; c < NUM_CH; c++) begin
        reg_rdata[c*FLD_STRIDE +: FLD_W] = ctrl_q[c];
        reg_rdata[RDY_BASE + c]          = busy_w[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (widx == WIDX_W'(c + 1)) reg_rdata = shadow_w[c];
      end
    end
  end

endmodule

// File: rtl/pwm2_ctl_chk.sv
module pwm2_ctl_chk
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [NUM_CH-1:0]             pwm_out,
  input logic [NUM_CH-1:0]             run_w,
  input logic [NUM_CH-1:0]             act_w,
  input logic [NUM_CH-1:0]             busy_w,
  input logic [NUM_CH-1:0][3:0]        code_w,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_w,
  input logic [NUM_CH-1:0][CNT_W-1:0]  duty_w
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic code_ok;
    assign code_ok = (ratio_of(code_w[c]) != '0);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w[c] |-> (pwm_out[c] == ~act_w[c])); // R3

    AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[c] && duty_w[c] == '0) |-> (pwm_out[c] == ~act_w[c])); // R4

    AST_BADCODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[c] && !code_ok) |=> (!run_w[c] || $stable(cnt_w[c]))); // R7

    AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_w[c] && busy_w[c]) |=> !busy_w[c]); // R9

    AST_BUSY_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[ADDR_W-1:2] == '0 && !busy_w[c]) |=> !busy_w[c]); // R10
  end

endmodule

bind pwm2_ctl pwm2_ctl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .pwm_out  (pwm_out),
  .run_w    (run_w),
  .act_w    (act_w),
  .busy_w   (busy_w),
  .code_w   (code_w),
  .cnt_w    (cnt_w),
  .duty_w   (duty_w)
);

// File: tb/pwm2_ctl_tb_top.sv
module pwm2_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pwm2_ctl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  function automatic logic [31:0] fld(input logic [3:0] code, input logic en,
                                      input logic act, input logic gate);
    return {22'd0, 3'b000, gate, act, en, code};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 outputs idle", {30'd0, pwm_out}, 32'd3);
    rd_reg(4'h0, d); chk("R11 ctrl zero", d, 32'd0);
    rd_reg(4'h4, d); chk("R11 ch0 zero", d, 32'd0);
    rd_reg(4'h8, d); chk("R11 ch1 zero", d, 32'd0);
  endtask

  task automatic t_ctrl_map();
    logic [31:0] d;
    wr_reg(4'h0, 32'hFFFF_FFFF);
    rd_reg(4'h0, d); chk("R2 field layout readback", d, 32'h01FF_83FF);
    wr_reg(4'h0, 32'h3000_0000);
    rd_reg(4'h0, d); chk("R10 busy bits not writable", d, 32'd0);
  endtask

  task automatic t_idle_write();
    logic [31:0] d;
    wr_reg(4'h4, 32'h0004_0002);
    rd_reg(4'h0, d); chk("R9 no busy on stopped write", d[29:28], 32'd0);
    rd_reg(4'h4, d); chk("R1 ch0 word readback", d, 32'h0004_0002);
  endtask

  task automatic t_wave(input logic act, input string req);
    wr_reg(4'h0, fld(4'd15, 1'b1, act, 1'b1));
    for (int k = 0; k < 10; k++) begin
      chk(req, {31'd0, pwm_out[0]}, {31'd0, ((k % 5) < 2) ? act : ~act});
      @(negedge clk);
    end
    wr_reg(4'h0, fld(4'd0, 1'b0, act, 1'b0));
    for (int k = 0; k < 4; k++) begin
      chk("R3 stopped output inactive", {31'd0, pwm_out[0]}, {31'd0, ~act});
      @(negedge clk);
    end
  endtask

  task automatic t_duty_edges();
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h4, 32'h0004_0000);
    wr_reg(4'h0, fld(4'd15, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k < 10; k++) begin
      chk("R4 duty zero never active", {31'd0, pwm_out[0]}, 32'd0);
      @(negedge clk);
    end
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h4, 32'h0004_0007);
    wr_reg(4'h0, fld(4'd15, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k < 10; k++) begin
      chk("R4 duty above period always active", {31'd0, pwm_out[0]}, 32'd1);
      @(negedge clk);
    end
  endtask

  task automatic t_gate();
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h4, 32'h0004_0002);
    wr_reg(4'h0, fld(4'd15, 1'b1, 1'b1, 1'b0));
    for (int k = 0; k < 6; k++) begin
      chk("R3 gate clear holds inactive", {31'd0, pwm_out[0]}, 32'd0);
      @(negedge clk);
    end
    wr_reg(4'h0, fld(4'd15, 1'b0, 1'b1, 1'b1));
    for (int k = 0; k < 6; k++) begin
      chk("R3 enable clear holds inactive", {31'd0, pwm_out[0]}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h4, 32'h0009_0003);
    wr_reg(4'h0, fld(4'd15, 1'b1, 1'b1, 1'b1));
    chk("R4 first cycle active", {31'd0, pwm_out[0]}, 32'd1);
    repeat (2) @(negedge clk);
    wr_reg(4'h4, 32'h0003_0001);
    rd_reg(4'h0, d); chk("R8 busy after running write", d[28], 32'd1);
    chk("R8 old value still drives", {31'd0, pwm_out[0]}, 32'd0);
    repeat (6) @(negedge clk);
    rd_reg(4'h0, d); chk("R8 busy holds to period end", d[28], 32'd1);
    @(negedge clk);
    rd_reg(4'h0, d); chk("R8 busy clears at wrap", d[28], 32'd0);
    for (int k = 0; k < 5; k++) begin
      chk("R8 new pattern after wrap", {31'd0, pwm_out[0]}, {31'd0, (k % 4) < 1});
      @(negedge clk);
    end
    rd_reg(4'h4, d); chk("R1 shadow readback", d, 32'h0003_0001);
  endtask

  task automatic t_presc();
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h4, 32'h0001_0001);
    wr_reg(4'h0, fld(4'd0, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k <= 240; k++) begin
      if (k == 0 || k == 119 || k == 120 || k == 239 || k == 240)
        chk("R6 code 0 divides by 120", {31'd0, pwm_out[0]}, {31'd0, (k < 120) || (k >= 240)});
      @(negedge clk);
    end
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h0, fld(4'd8, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k <= 12000; k++) begin
      if (k == 11999 || k == 12000)
        chk("R6 code 8 divides by 12000", {31'd0, pwm_out[0]}, {31'd0, k < 12000});
      @(negedge clk);
    end
  endtask

  task automatic t_badcode(input logic [3:0] code);
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h0, fld(code, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k < 300; k++) begin
      if (k % 50 == 49)
        chk("R7 unused code holds count", {31'd0, pwm_out[0]}, 32'd1);
      @(negedge clk);
    end
  endtask

  task automatic t_ch1();
    logic [31:0] d;
    wr_reg(4'h0, 32'd0);
    wr_reg(4'h8, 32'h0004_0001);
    wr_reg(4'h0, fld(4'd15, 1'b1, 1'b1, 1'b1) << 15);
    for (int k = 0; k < 10; k++) begin
      chk("R12 ch1 waveform", {31'd0, pwm_out[1]}, {31'd0, (k % 5) < 1});
      chk("R12 ch0 untouched", {31'd0, pwm_out[0]}, 32'd1);
      @(negedge clk);
    end
    rd_reg(4'h4, d); chk("R12 ch0 word untouched", d, 32'h0001_0001);
    rd_reg(4'h8, d); chk("R1 ch1 word readback", d, 32'h0004_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_map();
    t_idle_write();
    t_wave(1'b1, "R4 waveform active-high");
    t_wave(1'b0, "R5 waveform inverted");
    t_duty_edges();
    t_gate();
    t_shadow();
    t_presc();
    t_badcode(4'd5);
    t_badcode(4'd13);
    t_ch1();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule